// File: doc/BRIEF.md
# Set-Associative Tag Lookup Unit

This block probes one set of a set-associative tag array that it holds in flip-flops. It classifies each probe as a hit, a present miss or a total miss. A present miss is a way whose tag matches but whose line is not live, for example after an invalidation or a flush. A total miss means no way of the set carries the tag. The unit returns the way that matched. On a hit or a present miss it also refreshes per-way recency ages, where 1 marks the most recently used way and larger numbers mark older ways.

The caller states whether the probe comes from a first-level cache or a second-level cache:

- A first-level probe picks the set from the virtual address.
- A second-level probe picks the set from the physical address.
- In both cases the compared tag is taken from the physical address.

A small install port writes a tag and a live flag into a chosen way, so the array can be filled and invalidated. Two configuration inputs freeze the ages:

- one disables least-recently-used tracking;
- the other declares the cache infinite, so it never replaces a line.

Top module: `set_tag_lookup`

## Requirements
- R1: The set index is `req_vaddr[OFF_W +: IDX_W]` when `req_level` is 0 and `req_paddr[OFF_W +: IDX_W]` when `req_level` is 1. The tag is always the top TAG_W bits of `req_paddr`.
- R2: A matching way whose live flag is set gives `rsp_code` 0 (hit).
- R3: A matching way whose live flag is clear gives `rsp_code` 1 (present miss).
- R4: When no way of the set matches, `rsp_code` is 2 (total miss) and `rsp_way` is 0. Code 3 never appears.
- R5: Ways are compared from way 0 upward, and the lowest-numbered way whose tag matches is reported, whether that way is live or not.
- R6: On a hit with tracking enabled, the reported way's age becomes 1. Every other way of the set whose age was below the reported way's previous age gains 1, and the remaining ways keep their ages.
- R7: A present miss with tracking enabled changes the ages by the same rule as R6. A total miss leaves the ages unchanged.
- R8: When `cfg_lru` is 0 or `cfg_infinite` is 1, no lookup changes any age.
- R9: `rsp_valid`, `rsp_code`, `rsp_way` and the age update appear on the first clock edge after a cycle with `req_valid` high. `rsp_valid` is low after a cycle without a request.
- R10: After reset, every way has a clear live flag and a zero tag, and way w of every set has age w+1. `rsp_ages` packs way w at bits `[w*AGE_W +: AGE_W]`.
- R11: A cycle with `wr_en` high writes `wr_tag` and `wr_live` into way `wr_way` of set `wr_set` at the next edge and leaves every age untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_level | input | 1 | 0: first level (index from virtual address), 1: second level |
| req_vaddr | input | ADDR_W | Virtual address |
| req_paddr | input | ADDR_W | Physical address |
| cfg_lru | input | 1 | Age tracking enabled |
| cfg_infinite | input | 1 | Cache treated as infinite; ages frozen |
| wr_en | input | 1 | Install strobe |
| wr_set | input | IDX_W | Install set |
| wr_way | input | WAY_W | Install way |
| wr_tag | input | TAG_W | Installed tag |
| wr_live | input | 1 | Installed live flag |
| rsp_valid | output | 1 | Result valid |
| rsp_code | output | 2 | 0 hit, 1 present miss, 2 total miss |
| rsp_way | output | WAY_W | Matched way (0 on total miss) |
| rsp_ages | output | WAYS*AGE_W | Ages of the probed set after the update |

## Verification
The assertions assume that the ages of each set always form a permutation of 1 to WAYS. The block itself only guarantees this when it starts from reset, because an update keeps a permutation a permutation. The assertions also assume that `rsp_ages` reflects the set probed on the previous cycle. That holds because installs never touch ages.

The stimulus keeps installs and lookups in separate cycles, so a lookup never races an install to the same way. It draws tags from a pool of three values so that hits, present misses, duplicate tags within a set and total misses all occur often. It also toggles the level select and the two freeze inputs throughout the sweep.

// File: rtl/set_tag_lookup_pkg.sv
package set_tag_lookup_pkg;
    typedef enum logic [1:0] {
        LKP_HIT     = 2'd0,
        LKP_PRESENT = 2'd1,
        LKP_ABSENT  = 2'd2
    } lkp_code_e;
endpackage

// File: rtl/tla_way_match.sv
module tla_way_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 10,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [WAYS-1:0]            way_live,
    input  logic [TAG_W-1:0]           probe_tag,
    output logic                       found,
    output logic [WAY_W-1:0]           found_way,
    output logic                       found_live
);
    // Lowest-numbered matching way wins.
    always_comb begin
        found      = 1'b0;
        found_way  = '0;
        found_live = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!found && way_tag[w] == probe_tag) begin
                found      = 1'b1;
                found_way  = WAY_W'(w);
                found_live = way_live[w];
            end
        end
    end
endmodule

// File: rtl/tla_age_update.sv
module tla_age_update #(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2,
    parameter int AGE_W = 3
) (
    input  logic [WAYS-1:0][AGE_W-1:0] age_cur,
    input  logic                       touch,
    input  logic [WAY_W-1:0]           touch_way,
    output logic [WAYS-1:0][AGE_W-1:0] age_nxt
);
    logic [AGE_W-1:0] ref_age;
    assign ref_age = age_cur[touch_way];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        always_comb begin
            if (!touch)
                age_nxt[w] = age_cur[w];
            else if (touch_way == WAY_W'(w))
                age_nxt[w] = AGE_W'(1);
            else if (age_cur[w] < ref_age)
                age_nxt[w] = age_cur[w] + AGE_W'(1);
            else
                age_nxt[w] = age_cur[w];
        end
    end
endmodule

// File: rtl/set_tag_lookup.sv
module set_tag_lookup
    import set_tag_lookup_pkg::*;
#(
    parameter int WAYS       = 4,
    parameter int SETS       = 4,
    parameter int LINE_BYTES = 16,
    parameter int ADDR_W     = 16,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int IDX_W     = $clog2(SETS),
    localparam int TAG_W     = ADDR_W - OFF_W - IDX_W,
    localparam int WAY_W     = $clog2(WAYS),
    localparam int AGE_W     = $clog2(WAYS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_level,
    input  logic [ADDR_W-1:0]       req_vaddr,
    input  logic [ADDR_W-1:0]       req_paddr,
    input  logic                    cfg_lru,
    input  logic                    cfg_infinite,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_set,
    input  logic [WAY_W-1:0]        wr_way,
    input  logic [TAG_W-1:0]        wr_tag,
    input  logic                    wr_live,
    output logic                    rsp_valid,
    output logic [1:0]              rsp_code,
    output logic [WAY_W-1:0]        rsp_way,
    output logic [WAYS*AGE_W-1:0]   rsp_ages
);
    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag;
        logic [SETS-1:0][WAYS-1:0]            live;
        logic [SETS-1:0][WAYS-1:0][AGE_W-1:0] age;
        logic                                 rsp_valid;
        lkp_code_e                            rsp_code;
        logic [WAY_W-1:0]                     rsp_way;
        logic [IDX_W-1:0]                     rsp_set;
    } state_t;

    state_t st_q, st_d;

    logic [IDX_W-1:0]            req_set;
    logic [TAG_W-1:0]            req_tag;
    logic                        m_found, m_live;
    logic [WAY_W-1:0]            m_way;
    logic                        age_touch;
    logic [WAYS-1:0][AGE_W-1:0]  age_nxt;

    // Index source depends on cache level; tag is always physical.
    assign req_set = req_level ? req_paddr[OFF_W +: IDX_W] : req_vaddr[OFF_W +: IDX_W];
    assign req_tag = req_paddr[ADDR_W-1 -: TAG_W];

    tla_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
        .way_tag    (st_q.tag[req_set]),
        .way_live   (st_q.live[req_set]),
        .probe_tag  (req_tag),
        .found      (m_found),
        .found_way  (m_way),
        .found_live (m_live)
    );

    assign age_touch = req_valid && m_found && cfg_lru && !cfg_infinite;

    tla_age_update #(.WAYS(WAYS), .WAY_W(WAY_W), .AGE_W(AGE_W)) u_age (
        .age_cur   (st_q.age[req_set]),
        .touch     (age_touch),
        .touch_way (m_way),
        .age_nxt   (age_nxt)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = req_valid;
        if (req_valid) begin
            st_d.rsp_set = req_set;
            st_d.rsp_way = m_found ? m_way : '0;
            if (!m_found)
                st_d.rsp_code = LKP_ABSENT;
            else if (m_live)
                st_d.rsp_code = LKP_HIT;
            else
                st_d.rsp_code = LKP_PRESENT;
            st_d.age[req_set] = age_nxt;
        end
        if (wr_en) begin
            st_d.tag[wr_set][wr_way]  = wr_tag;
            st_d.live[wr_set][wr_way] = wr_live;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    st_q.age[s][w] <= AGE_W'(w + 1);
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_code  = st_q.rsp_code;
    assign rsp_way   = st_q.rsp_way;
    assign rsp_ages  = st_q.age[st_q.rsp_set];
endmodule

// File: rtl/set_tag_lookup_chk.sv
module set_tag_lookup_chk #(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2,
    parameter int AGE_W = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic                  cfg_lru,
    input logic                  cfg_infinite,
    input logic                  rsp_valid,
    input logic [1:0]            rsp_code,
    input logic [WAY_W-1:0]      rsp_way,
    input logic [WAYS*AGE_W-1:0] rsp_ages
);
    logic [WAYS-1:0][AGE_W-1:0] ages_v;
    assign ages_v = rsp_ages;

    // R9
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R9
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R4
    absent_way_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 2'd2) |-> rsp_way == '0);

    // R4
    code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_code != 2'd3);

    // R6
    touched_age_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cfg_lru && !cfg_infinite) |=>
            (rsp_code == 2'd2 || ages_v[rsp_way] == AGE_W'(1)));

    for (genvar w = 0; w < WAYS; w++) begin : g_rng
        // R10
        age_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_valid |-> (ages_v[w] != '0 && ages_v[w] <= AGE_W'(WAYS)));
    end
endmodule

bind set_tag_lookup set_tag_lookup_chk #(.WAYS(WAYS), .WAY_W(WAY_W), .AGE_W(AGE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .cfg_lru      (cfg_lru),
    .cfg_infinite (cfg_infinite),
    .rsp_valid    (rsp_valid),
    .rsp_code     (rsp_code),
    .rsp_way      (rsp_way),
    .rsp_ages     (rsp_ages)
);

// File: tb/set_tag_lookup_tb.sv
`timescale 1ns/1ps
module set_tag_lookup_tb;
    localparam int WAYS = 4, SETS = 4, ADDR_W = 16;
    localparam int OFF_W = 4, IDX_W = 2, TAG_W = 10, WAY_W = 2, AGE_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_level = 1'b0;
    logic [ADDR_W-1:0] req_vaddr = '0, req_paddr = '0;
    logic cfg_lru = 1'b1, cfg_infinite = 1'b0;
    logic wr_en = 1'b0;
    logic [IDX_W-1:0] wr_set = '0;
    logic [WAY_W-1:0] wr_way = '0;
    logic [TAG_W-1:0] wr_tag = '0;
    logic wr_live = 1'b0;
    logic rsp_valid;
    logic [1:0] rsp_code;
    logic [WAY_W-1:0] rsp_way;
    logic [WAYS*AGE_W-1:0] rsp_ages;

    always #2.5 clk = ~clk;

    set_tag_lookup u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
        .req_vaddr(req_vaddr), .req_paddr(req_paddr), .cfg_lru(cfg_lru),
        .cfg_infinite(cfg_infinite), .wr_en(wr_en), .wr_set(wr_set), .wr_way(wr_way),
        .wr_tag(wr_tag), .wr_live(wr_live), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .rsp_way(rsp_way), .rsp_ages(rsp_ages)
    );

    int errors = 0, checks = 0;
    bit done = 1'b0;
    int m_tag [SETS][WAYS];
    bit m_live[SETS][WAYS];
    int m_age [SETS][WAYS];

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int pack_ages(int s);
        int v = 0;
        for (int w = 0; w < WAYS; w++) v |= (m_age[s][w] << (w * AGE_W));
        return v;
    endfunction

    task automatic install(int s, int w, int t, bit lv);
        @(negedge clk);
        wr_en = 1'b1; wr_set = IDX_W'(s); wr_way = WAY_W'(w);
        wr_tag = TAG_W'(t); wr_live = lv;
        @(negedge clk);
        wr_en = 1'b0;
        m_tag[s][w] = t; m_live[s][w] = lv;
    endtask

    // Build addresses from set/tag pieces and compare against the model.
    task automatic lookup(bit lvl, int vset, int pset, int t, bit lru, bit inf, string rtag);
        int s, code, way, old;
        bit found = 0;
        bit touch;
        s = lvl ? pset : vset;
        code = 2; way = 0;
        for (int w = 0; w < WAYS; w++)
            if (!found && m_tag[s][w] == t) begin
                found = 1; way = w; code = m_live[s][w] ? 0 : 1;
            end
        touch = found && lru && !inf;
        if (touch) begin
            old = m_age[s][way];
            for (int w = 0; w < WAYS; w++)
                if (w == way) m_age[s][w] = 1;
                else if (m_age[s][w] < old) m_age[s][w]++;
        end
        @(negedge clk);
        req_valid = 1'b1; req_level = lvl; cfg_lru = lru; cfg_infinite = inf;
        req_paddr = {TAG_W'(t), IDX_W'(pset), OFF_W'($urandom)};
        req_vaddr = {TAG_W'($urandom), IDX_W'(vset), OFF_W'($urandom)};
        @(negedge clk);
        req_valid = 1'b0;
        check({rtag, " R9 valid"}, int'(rsp_valid), 1);
        check(code == 0 ? "R2 code" : code == 1 ? "R3 code" : "R4 code", int'(rsp_code), code);
        check(code == 2 ? "R4 way" : "R5 way", int'(rsp_way), way);
        check(!found ? "R7 ages frozen on total miss" : !(lru && !inf) ? "R8 ages" :
              code == 0 ? "R6 ages" : "R7 ages", int'(rsp_ages), pack_ages(s));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_tag[s][w] = 0; m_live[s][w] = 0; m_age[s][w] = w + 1;
            end
        repeat (3) @(negedge clk);
        check("R10 rsp_valid in reset", int'(rsp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 idle rsp_valid", int'(rsp_valid), 0);

        // R10: reset ages and cleared tags, seen through every set
        for (int s = 0; s < SETS; s++) lookup(1, s, s, 10'h3FF, 1, 0, "R10 reset ages");
        lookup(1, 0, 2, 0, 0, 0, "R10 zero tag invalid");

        // R11 and R6: install then hit
        install(1, 2, 5, 1);
        lookup(1, 0, 1, 5, 1, 0, "R11 R6 hit");
        check("R6 directed ages", int'(rsp_ages), 'h1 << 6 | 'h4 << 9 | 'h2 | 'h3 << 3);
        @(negedge clk);
        check("R9 no request", int'(rsp_valid), 0);

        // R1: level picks index source; tag from physical address
        lookup(0, 1, 3, 5, 1, 0, "R1 level0");
        check("R1 level0 hit", int'(rsp_code), 0);
        lookup(1, 1, 3, 5, 1, 0, "R1 level1");
        check("R1 level1 miss", int'(rsp_code), 2);

        // R5: duplicate tag, lower way invalid wins
        install(1, 0, 5, 0);
        lookup(1, 0, 1, 5, 1, 0, "R5 dup");
        check("R5 dup way", int'(rsp_way), 0);

        // R8: frozen ages
        lookup(1, 0, 1, 5, 0, 0, "R8 lru off");
        lookup(1, 0, 1, 5, 1, 1, "R8 infinite");

        // Sweep
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 9) < 3)
                install($urandom_range(0, SETS-1), $urandom_range(0, WAYS-1),
                        $urandom_range(1, 3), 1'($urandom_range(0, 3) != 0));
            else
                lookup(1'($urandom), $urandom_range(0, SETS-1), $urandom_range(0, SETS-1),
                       $urandom_range(1, 3), $urandom_range(0, 9) < 8,
                       $urandom_range(0, 9) == 0, "sweep");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule